// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block sits between the wakeup logic and the functional units of an out-of-order core. Every ready instruction arrives on a single insert port with a sequence number, an operation-class tag and a thread tag. It is stored in the ready pool of its class. Each pool keeps its entries sorted oldest first, so the head of every pool is that class's oldest ready instruction.

In each cycle a picker compares the heads of all classes whose functional unit is free. It takes the globally oldest, advances that class to its next entry, and repeats until the issue width is used up or nothing eligible remains. The picks go out on a per-slot issue bus in ascending age, and the chosen entries leave their pools at the next clock edge. A squash port removes the speculative tail of one thread. A squash has priority over both issue and insert in the cycle it is asserted.

A two-state controller tracks whether any pool holds entries. The state `ST_EMPTY` moves to `ST_LOADED` on the transition *fill*, when the pools will hold at least one entry after the edge. `ST_LOADED` returns to `ST_EMPTY` on the transition *drain*, when every pool will be empty after the edge. Each state otherwise holds. Issue and busy-event counting are enabled only in `ST_LOADED` and outside squash cycles.

Top module: `issue_age_sel`

## Requirements
- R1: One insert per cycle is written into the pool named by the class tag (binary, 0 to NCLS-1). A tag of NCLS or above is dropped. Each pool holds DEPTH (8) entries, and `pool_full` of a class is high exactly when its pool holds DEPTH entries. An insert into a full pool is dropped. An inserted entry can issue from the next cycle on.
- R2: Within one class, an entry with an older sequence number issues before any younger entry of that class, whatever the order in which they were inserted.
- R3: Across classes, the issued entries are the oldest eligible ones. Slot 0 carries the oldest, and higher slots carry successively younger entries. `iss_valid` of every unused slot is low, and used slots are contiguous from slot 0.
- R4: At most ISSUE_W (2) instructions issue per cycle, and several may come from the same class in one cycle.
- R5: A class whose `fu_avail` bit is low issues nothing that cycle, and younger entries of other classes may issue in its place. In every non-squash cycle, `busy_events` increases by the number of classes that hold entries but have `fu_avail` low. The counter wraps at 2^16.
- R6: Age is wrap-aware over the 16-bit sequence number: a is older than b exactly when bit 15 of (a - b) mod 2^16 is set.
- R7: A squash removes every entry whose thread equals `squash_tid` and whose sequence number is younger than `squash_seq`. An entry equal to `squash_seq`, any older entry, and every entry of another thread are kept in their order.
- R8: In a squash cycle all `iss_valid` bits are low, nothing leaves the pools through issue, the insert is dropped and `busy_events` holds its value.
- R9: After reset, all pools are empty, all `iss_valid` and `pool_full` bits are low, and `busy_events` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_cls | input | CLS_W | Operation-class tag of the insert |
| ins_seq | input | 16 | Sequence number of the insert |
| ins_tid | input | 1 | Thread tag of the insert |
| fu_avail | input | NCLS | Per-class functional unit free flag |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | 1 | Thread to squash |
| squash_seq | input | 16 | Youngest surviving sequence number |
| pool_full | output | NCLS | Per-class pool full flag |
| iss_valid | output | ISSUE_W | Per-slot issue valid |
| iss_seq | output | ISSUE_W x 16 | Per-slot sequence number |
| iss_cls | output | ISSUE_W x CLS_W | Per-slot class tag |
| iss_tid | output | ISSUE_W | Per-slot thread tag |
| busy_events | output | 16 | Count of busy-unit skips |

## Verification
The selection is exercised with several kinds of input. Entries inserted out of order into one class show whether each pool sorts by age or keeps arrival order. Competing heads of three classes check that the picker compares across classes. A single class holding many entries shows that the width limit applies and that one class may fill both slots. Masking units off checks skipping and the busy count. Sequence numbers that straddle the wrap point tell wrap-aware comparison apart from plain magnitude. A squash that mixes both threads, an equal sequence number and a concurrent insert shows what is removed and what is kept. A long randomized sweep with occasional squashes is then compared every cycle against an arithmetic model of global oldest-first selection.

// File: rtl/issue_age_sel_pkg.sv
package issue_age_sel_pkg;
    localparam int SEQ_W = 16;
    localparam int TID_W = 1;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [TID_W-1:0] tid_t;

    typedef struct packed {
        seq_t seq;
        tid_t tid;
    } slot_ent_t;

    // a older than b: sign of the modular difference
    function automatic logic seq_older(input seq_t a, input seq_t b);
        seq_t d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction
endpackage

// File: rtl/ias_pool.sv
module ias_pool
    import issue_age_sel_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int POP_MAX = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int POP_W  = $clog2(POP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  slot_ent_t        ins_ent,
    input  logic [POP_W-1:0] pop_n,
    input  logic             sq_en,
    input  tid_t             sq_tid,
    input  seq_t             sq_seq,
    output slot_ent_t        head_o [POP_MAX],
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nx_o,
    output logic             full_o
);

    slot_ent_t        ents [DEPTH];
    slot_ent_t        nxt  [DEPTH];
    slot_ent_t        shf  [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    assign full_o   = (cnt_q == CNT_W'(DEPTH));
    assign cnt_o    = cnt_q;
    assign cnt_nx_o = cnt_d;

    always_comb begin
        int pos;
        int pn;
        int base;
        int ipos;
        nxt   = ents;
        shf   = ents;
        pos   = 0;
        ipos  = 0;
        pn    = int'(pop_n);
        base  = int'(cnt_q) - pn;
        cnt_d = cnt_q;
        if (sq_en) begin
            // keep survivors, compact toward index 0 preserving order
            for (int i = 0; i < DEPTH; i++) begin
                if (i < int'(cnt_q) &&
                    !(ents[i].tid == sq_tid && seq_older(sq_seq, ents[i].seq))) begin
                    nxt[pos] = ents[i];
                    pos++;
                end
            end
            cnt_d = CNT_W'(pos);
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                shf[i] = (i + pn < DEPTH) ? ents[(i + pn) % DEPTH] : '0;
            end
            if (ins_en && !full_o) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (i < base && seq_older(shf[i].seq, ins_ent.seq)) ipos++;
                end
                for (int i = 0; i < DEPTH; i++) begin
                    if (i < ipos)       nxt[i] = shf[i];
                    else if (i == ipos) nxt[i] = ins_ent;
                    else                nxt[i] = shf[(i == 0) ? 0 : i - 1];
                end
                cnt_d = CNT_W'(base + 1);
            end else begin
                nxt   = shf;
                cnt_d = CNT_W'(base);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            ents  <= nxt;
        end
    end

    generate
        for (genvar k = 0; k < POP_MAX; k++) begin : g_head
            assign head_o[k] = ents[k];
        end
    endgenerate

    generate
        for (genvar i = 0; i < DEPTH - 1; i++) begin : g_ord
            // R2
            pool_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(cnt_o) > i + 1) |-> !seq_older(ents[i+1].seq, ents[i].seq));
        end
    endgenerate

    // R1
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && full_o && !sq_en) |=> (cnt_o == $past(cnt_o) - CNT_W'($past(pop_n))));

    // R8
    squash_nogrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_en |=> (cnt_o <= $past(cnt_o)));

endmodule

// File: rtl/ias_pick.sv
module ias_pick
    import issue_age_sel_pkg::*;
#(
    parameter int NCLS    = 3,
    parameter int ISSUE_W = 2,
    parameter int DEPTH   = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int POP_W  = $clog2(ISSUE_W + 1),
    localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  slot_ent_t          heads [NCLS][ISSUE_W],
    input  logic [CNT_W-1:0]   cnts  [NCLS],
    input  logic [NCLS-1:0]    fu_avail,
    output logic [ISSUE_W-1:0] sl_v,
    output slot_ent_t          sl_e  [ISSUE_W],
    output logic [CLS_W-1:0]   sl_c  [ISSUE_W],
    output logic [POP_W-1:0]   pop_n [NCLS]
);

    always_comb begin
        int        taken [NCLS];
        int        bc;
        logic      found;
        slot_ent_t best;
        slot_ent_t cand;
        for (int c = 0; c < NCLS; c++) taken[c] = 0;
        for (int k = 0; k < ISSUE_W; k++) begin
            found = 1'b0;
            best  = '0;
            cand  = '0;
            bc    = 0;
            for (int c = 0; c < NCLS; c++) begin
                if (en && fu_avail[c] && taken[c] < ISSUE_W &&
                    int'(cnts[c]) > taken[c]) begin
                    cand = heads[c][taken[c]];
                    if (!found || seq_older(cand.seq, best.seq)) begin
                        found = 1'b1;
                        best  = cand;
                        bc    = c;
                    end
                end
            end
            sl_v[k] = found;
            sl_e[k] = best;
            sl_c[k] = CLS_W'(bc);
            if (found) taken[bc] = taken[bc] + 1;
        end
        for (int c = 0; c < NCLS; c++) pop_n[c] = POP_W'(taken[c]);
    end

    generate
        for (genvar k = 0; k < ISSUE_W; k++) begin : g_fu
            // R5
            fu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sl_v[k] |-> fu_avail[sl_c[k]]);
        end
        for (genvar k = 0; k < ISSUE_W - 1; k++) begin : g_slot
            // R3
            slot_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sl_v[k+1] |-> sl_v[k]);
            // R3
            slot_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sl_v[k+1] |-> seq_older(sl_e[k].seq, sl_e[k+1].seq));
        end
    endgenerate

endmodule

// File: rtl/ias_ctrl.sv
module ias_ctrl #(
    parameter int NCLS   = 3,
    parameter int DEPTH  = 8,
    parameter int BUSY_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sq_en,
    input  logic [CNT_W-1:0]  cnts    [NCLS],
    input  logic [CNT_W-1:0]  cnts_nx [NCLS],
    input  logic [NCLS-1:0]   fu_avail,
    output logic              issue_en,
    output logic [BUSY_W-1:0] busy_cnt
);

    typedef enum logic {
        ST_EMPTY,
        ST_LOADED
    } ctl_st_t;

    ctl_st_t           st_q;
    ctl_st_t           st_d;
    logic [NCLS-1:0]   occ;
    logic [NCLS-1:0]   occ_nx;
    logic [BUSY_W-1:0] busy_inc;

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_occ
            assign occ[c]    = |cnts[c];
            assign occ_nx[c] = |cnts_nx[c];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY:  if (|occ_nx)  st_d = ST_LOADED;   // fill
            ST_LOADED: if (!(|occ_nx)) st_d = ST_EMPTY;  // drain
            default:   st_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        issue_en = 1'b0;
        busy_inc = '0;
        unique case (st_q)
            ST_EMPTY: begin
                issue_en = 1'b0;
            end
            ST_LOADED: begin
                issue_en = !sq_en;
                if (!sq_en) begin
                    for (int c = 0; c < NCLS; c++) begin
                        if (occ[c] && !fu_avail[c]) busy_inc = busy_inc + BUSY_W'(1);
                    end
                end
            end
            default: issue_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= '0;
        else        busy_cnt <= busy_cnt + busy_inc;
    end

    // R9
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMPTY) |-> (occ == '0));

    // R8
    sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_en |=> $stable(busy_cnt));

    // R5
    busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sq_en && ((occ & ~fu_avail) != '0)) |=> (busy_cnt != $past(busy_cnt)));

endmodule

// File: rtl/issue_age_sel.sv
module issue_age_sel
    import issue_age_sel_pkg::*;
#(
    parameter int NCLS    = 3,
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 2,
    parameter int BUSY_W  = 16,
    localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int POP_W  = $clog2(ISSUE_W + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ins_valid,
    input  logic [CLS_W-1:0]                ins_cls,
    input  logic [SEQ_W-1:0]                ins_seq,
    input  logic [TID_W-1:0]                ins_tid,
    input  logic [NCLS-1:0]                 fu_avail,
    input  logic                            squash_valid,
    input  logic [TID_W-1:0]                squash_tid,
    input  logic [SEQ_W-1:0]                squash_seq,
    output logic [NCLS-1:0]                 pool_full,
    output logic [ISSUE_W-1:0]              iss_valid,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]   iss_seq,
    output logic [ISSUE_W-1:0][CLS_W-1:0]   iss_cls,
    output logic [ISSUE_W-1:0][TID_W-1:0]   iss_tid,
    output logic [BUSY_W-1:0]               busy_events
);

    slot_ent_t        heads   [NCLS][ISSUE_W];
    logic [CNT_W-1:0] cnts    [NCLS];
    logic [CNT_W-1:0] cnts_nx [NCLS];
    logic [POP_W-1:0] pops    [NCLS];
    slot_ent_t        sl_e    [ISSUE_W];
    logic [CLS_W-1:0] sl_c    [ISSUE_W];
    logic             issue_en;
    slot_ent_t        ins_ent;

    assign ins_ent = '{seq: ins_seq, tid: ins_tid};

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_pool
            logic ins_hit;
            assign ins_hit = ins_valid && (ins_cls == CLS_W'(c));
            ias_pool #(
                .DEPTH   (DEPTH),
                .POP_MAX (ISSUE_W)
            ) pool_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .ins_en   (ins_hit),
                .ins_ent  (ins_ent),
                .pop_n    (pops[c]),
                .sq_en    (squash_valid),
                .sq_tid   (squash_tid),
                .sq_seq   (squash_seq),
                .head_o   (heads[c]),
                .cnt_o    (cnts[c]),
                .cnt_nx_o (cnts_nx[c]),
                .full_o   (pool_full[c])
            );
        end
    endgenerate

    ias_ctrl #(
        .NCLS   (NCLS),
        .DEPTH  (DEPTH),
        .BUSY_W (BUSY_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sq_en    (squash_valid),
        .cnts     (cnts),
        .cnts_nx  (cnts_nx),
        .fu_avail (fu_avail),
        .issue_en (issue_en),
        .busy_cnt (busy_events)
    );

    ias_pick #(
        .NCLS    (NCLS),
        .ISSUE_W (ISSUE_W),
        .DEPTH   (DEPTH)
    ) pick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (issue_en),
        .heads    (heads),
        .cnts     (cnts),
        .fu_avail (fu_avail),
        .sl_v     (iss_valid),
        .sl_e     (sl_e),
        .sl_c     (sl_c),
        .pop_n    (pops)
    );

    generate
        for (genvar k = 0; k < ISSUE_W; k++) begin : g_out
            assign iss_seq[k] = sl_e[k].seq;
            assign iss_tid[k] = sl_e[k].tid;
            assign iss_cls[k] = sl_c[k];
        end
    endgenerate

    // R8
    squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> (iss_valid == '0));

endmodule

// File: tb/issue_age_sel_tb_top.sv
`timescale 1ns/1ps
module issue_age_sel_tb_top;
    localparam int NC = 3;
    localparam int DP = 8;
    localparam int IW = 2;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                ins_valid;
    logic [1:0]          ins_cls;
    logic [15:0]         ins_seq;
    logic [0:0]          ins_tid;
    logic [NC-1:0]       fu_avail;
    logic                squash_valid;
    logic [0:0]          squash_tid;
    logic [15:0]         squash_seq;
    logic [NC-1:0]       pool_full;
    logic [IW-1:0]       iss_valid;
    logic [IW-1:0][15:0] iss_seq;
    logic [IW-1:0][1:0]  iss_cls;
    logic [IW-1:0][0:0]  iss_tid;
    logic [15:0]         busy_events;

    always #10 clk = ~clk;

    issue_age_sel #(.NCLS(NC), .DEPTH(DP), .ISSUE_W(IW), .BUSY_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_cls(ins_cls),
        .ins_seq(ins_seq), .ins_tid(ins_tid), .fu_avail(fu_avail),
        .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_seq(squash_seq),
        .pool_full(pool_full), .iss_valid(iss_valid), .iss_seq(iss_seq),
        .iss_cls(iss_cls), .iss_tid(iss_tid), .busy_events(busy_events)
    );

    int n_chk = 0;
    int n_err = 0;
    int mseq [NC][DP];
    int mtid [NC][DP];
    int mcnt [NC];
    int exp_busy = 0;
    bit done = 0;

    // R6: a older than b when bit 15 of (a-b) mod 2^16 is set
    function automatic bit older(input int a, input int b);
        return (((a - b) & 32'hFFFF) >= 32'h8000);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit iv, input int icls, input int iseq,
                        input int itid, input bit [NC-1:0] fu, input bit sq = 0,
                        input int stid = 0, input int sseq = 0);
        bit ev [IW];
        int es [IW];
        int ec [IW];
        int et [IW];
        bit used [NC][DP];
        int pops [NC];
        int bc;
        int bi;
        int p;
        @(negedge clk);
        ins_valid    = iv;
        ins_cls      = 2'(icls);
        ins_seq      = 16'(iseq);
        ins_tid      = 1'(itid);
        fu_avail     = fu;
        squash_valid = sq;
        squash_tid   = 1'(stid);
        squash_seq   = 16'(sseq);
        #1;
        for (int c = 0; c < NC; c++) begin
            pops[c] = 0;
            for (int i = 0; i < DP; i++) used[c][i] = 0;
        end
        for (int k = 0; k < IW; k++) begin
            ev[k] = 0; es[k] = 0; ec[k] = 0; et[k] = 0; bc = 0; bi = 0;
            if (!sq) begin
                for (int c = 0; c < NC; c++) begin
                    if (fu[c]) begin
                        for (int i = 0; i < mcnt[c]; i++) begin
                            if (!used[c][i] && (!ev[k] || older(mseq[c][i], es[k]))) begin
                                ev[k] = 1; es[k] = mseq[c][i]; ec[k] = c;
                                et[k] = mtid[c][i]; bc = c; bi = i;
                            end
                        end
                    end
                end
            end
            if (ev[k]) begin
                used[bc][bi] = 1;
                pops[bc]++;
            end
        end
        for (int k = 0; k < IW; k++) begin
            chk(iss_valid[k] == ev[k], tag, $sformatf("slot%0d valid", k),
                int'(iss_valid[k]), int'(ev[k]));
            if (ev[k]) begin
                chk(int'(iss_seq[k]) == es[k], tag, $sformatf("slot%0d seq", k),
                    int'(iss_seq[k]), es[k]);
                chk(int'(iss_cls[k]) == ec[k], tag, $sformatf("slot%0d class", k),
                    int'(iss_cls[k]), ec[k]);
                chk(int'(iss_tid[k]) == et[k], tag, $sformatf("slot%0d thread", k),
                    int'(iss_tid[k]), et[k]);
            end
        end
        for (int c = 0; c < NC; c++) begin
            chk(pool_full[c] == (mcnt[c] == DP), "R1", $sformatf("full c%0d", c),
                int'(pool_full[c]), int'(mcnt[c] == DP));
        end
        @(posedge clk);
        if (!sq) begin
            for (int c = 0; c < NC; c++) if (mcnt[c] > 0 && !fu[c]) exp_busy++;
        end
        if (sq) begin
            for (int c = 0; c < NC; c++) begin
                p = 0;
                for (int i = 0; i < mcnt[c]; i++) begin
                    if (!(mtid[c][i] == stid && older(sseq, mseq[c][i]))) begin
                        mseq[c][p] = mseq[c][i]; mtid[c][p] = mtid[c][i]; p++;
                    end
                end
                mcnt[c] = p;
            end
        end else begin
            for (int c = 0; c < NC; c++) begin
                for (int i = 0; i + pops[c] < mcnt[c]; i++) begin
                    mseq[c][i] = mseq[c][i + pops[c]];
                    mtid[c][i] = mtid[c][i + pops[c]];
                end
                mcnt[c] -= pops[c];
            end
            if (iv && icls < NC && mcnt[icls] < DP) begin
                p = 0;
                for (int i = 0; i < mcnt[icls]; i++) if (older(mseq[icls][i], iseq)) p++;
                for (int i = mcnt[icls]; i > p; i--) begin
                    mseq[icls][i] = mseq[icls][i-1]; mtid[icls][i] = mtid[icls][i-1];
                end
                mseq[icls][p] = iseq & 16'hFFFF; mtid[icls][p] = itid & 1;
                mcnt[icls]++;
            end
        end
        #1;
        chk(int'(busy_events) == (exp_busy & 16'hFFFF), sq ? "R8" : "R5", "busy count",
            int'(busy_events), exp_busy & 16'hFFFF);
    endtask

    task automatic idle(input string tag, input bit [NC-1:0] fu, input int n);
        for (int j = 0; j < n; j++) step(tag, 0, 0, 0, 0, fu);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int gseq;
        int r;
        for (int c = 0; c < NC; c++) mcnt[c] = 0;
        rst_n = 0; ins_valid = 0; ins_cls = 0; ins_seq = 0; ins_tid = 0;
        fu_avail = '0; squash_valid = 0; squash_tid = 0; squash_seq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(iss_valid == '0, "R9", "reset issue", int'(iss_valid), 0);
        chk(pool_full == '0, "R9", "reset full", int'(pool_full), 0);
        chk(busy_events == 16'd0, "R9", "reset busy", int'(busy_events), 0);
        rst_n = 1;

        // R2: out-of-order inserts into one class
        step("R2", 1, 0, 5, 0, 3'b000);
        step("R2", 1, 0, 3, 0, 3'b000);
        step("R2", 1, 0, 9, 0, 3'b000);
        idle("R2", 3'b001, 3);

        // R3: competing heads across classes
        step("R3", 1, 0, 10, 0, 3'b000);
        step("R3", 1, 1, 7, 1, 3'b000);
        step("R3", 1, 2, 12, 0, 3'b000);
        idle("R3", 3'b111, 3);

        // R4: one class supplies both slots, width limit
        step("R4", 1, 1, 20, 0, 3'b000);
        step("R4", 1, 1, 21, 0, 3'b000);
        step("R4", 1, 1, 22, 1, 3'b000);
        step("R4", 1, 1, 23, 0, 3'b000);
        idle("R4", 3'b111, 3);

        // R5: busy class skipped and counted
        step("R5", 1, 0, 30, 0, 3'b000);
        step("R5", 1, 1, 25, 0, 3'b000);
        step("R5", 1, 2, 31, 0, 3'b000);
        idle("R5", 3'b101, 2);
        idle("R5", 3'b010, 2);

        // R6: wrap-aware ordering
        step("R6", 1, 0, 16'h0002, 0, 3'b000);
        step("R6", 1, 2, 16'hFFFE, 1, 3'b000);
        idle("R6", 3'b111, 3);

        // R1: fill class 2, overfill, invalid class tag, same-cycle insert not issued
        for (int j = 0; j < 9; j++) step("R1", 1, 2, 40 + j, 0, 3'b000);
        step("R1", 1, 3, 1, 0, 3'b111);
        step("R1", 1, 0, 60, 0, 3'b011);
        idle("R1", 3'b111, 6);

        // R7 / R8: selective squash with concurrent insert
        step("R7", 1, 0, 50, 1, 3'b000);
        step("R7", 1, 0, 52, 0, 3'b000);
        step("R7", 1, 1, 54, 1, 3'b000);
        step("R7", 1, 1, 51, 1, 3'b000);
        step("R7", 1, 2, 56, 0, 3'b000);
        step("R8", 1, 2, 49, 1, 3'b111, 1, 1, 51);
        idle("R7", 3'b111, 4);

        // randomized sweep across the wrap point
        gseq = 16'hFF80;
        for (int j = 0; j < 3000; j++) begin
            r = $urandom;
            if (r % 41 == 0) begin
                step("R7", (r % 2) == 1, (r >> 3) % 4, gseq, (r >> 5) % 2, 3'(r >> 7),
                     1, (r >> 10) % 2, (gseq - 1 - ((r >> 12) % 12)) & 16'hFFFF);
            end else begin
                step("R3", (r % 4) != 0, (r >> 3) % 4, gseq, (r >> 5) % 2, 3'(r >> 7));
            end
            gseq = (gseq + 1) & 16'hFFFF;
        end
        idle("R3", 3'b111, 12);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule